// File: doc/BRIEF.md
# USB Bus Turnaround Timeout Timer

This block watches the quiet interval that follows a USB packet when a reply is due. The interval is measured in full-speed bit times, taken from a one-cycle tick supplied by the line interface. A reply is due in two places: after the token of a SETUP or OUT transaction, when data should follow, and after the data of an IN transaction, when a handshake should follow. Surrounding logic raises a response-expected flag for exactly those gaps.

The timer arms when an end-of-packet strobe arrives while that flag is high, and counts bit ticks from that moment. If the line leaves the idle state before the limit, the reply has started, and the timer disarms silently. If more than `LIMIT` bit times (16 by default) go by while the line stays idle, the block emits a one-cycle timeout pulse. The pulse is meant to set the turnaround-timeout flag in the error status register, which is bit 4 of that register. Line decoding and packet parsing are done elsewhere.

Top module: `usb_turnaround_timer`

## Requirements
- R1: While `rst_n` is low at a clock edge, the timer becomes disarmed with its count at zero and `timeout_pulse` low. Bit ticks after reset with no qualifying end-of-packet produce no pulse.
- R2: An `eop_strobe` sampled high together with `resp_expected` high arms the timer, with its count at zero from that edge.
- R3: An `eop_strobe` with `resp_expected` low leaves a disarmed timer disarmed, so no number of ticks that follow produces a pulse.
- R4: The count advances only on cycles where `bit_tick` is high. Idle clock cycles between ticks do not move the timeout.
- R5: While armed and idle, the tick that makes the count exceed `LIMIT` (the 17th tick by default) raises `timeout_pulse` in the cycle after the edge that samples it. `LIMIT` ticks alone give no pulse.
- R6: `timeout_pulse` is high for exactly one cycle. The timer is disarmed from that point, and later ticks give no pulse until the next qualifying end-of-packet.
- R7: `line_idle` sampled low while armed disarms the timer without a pulse, and later ticks give no pulse.
- R8: A qualifying end-of-packet while already armed restarts the count at zero. It takes precedence over a non-idle line and over a tick sampled in the same cycle.
- R9: A cycle that has both a tick and `line_idle` low is a cancel, even when the count stands at `LIMIT`. No pulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bit_tick | input | 1 | One-cycle strobe per full-speed bit time |
| eop_strobe | input | 1 | One-cycle strobe at the end of a packet |
| line_idle | input | 1 | High while the bus is in the idle state |
| resp_expected | input | 1 | High when the packet just ending must be answered |
| timeout_pulse | output | 1 | One-cycle turnaround timeout indication |

## Verification
The hardest situations to reach are the ones where several events meet the count at its last step: a cancel on the same cycle as the would-be expiring tick, and a restart partway through a count. The stimulus reaches these by walking a table of transactions. Each entry chooses the tick count, the spacing between ticks and the tick before which the line goes busy, so a cancel can be placed exactly one tick before expiry. Directed sequences then put ticks, end-of-packet and a busy line into the same cycle at count `LIMIT`, and apply reset partway through a count.

// File: rtl/tat_pkg.sv
// Shared types for the turnaround timer.
// Assumes: nothing beyond IEEE 1800-2017 synthesizable subset.
package tat_pkg;

    // Arm state of the timer.
    typedef enum logic {
        TAT_IDLE  = 1'b0,
        TAT_ARMED = 1'b1
    } tat_state_e;

    // Bits needed to hold counts 0..limit inclusive.
    function automatic int unsigned cnt_width(input int unsigned limit);
        return (limit < 1) ? 1 : $clog2(limit + 1);
    endfunction

endpackage

// File: rtl/tat_line_qual.sv
// Qualifies the raw line-side strobes for the timer.
// Produces the qualifying end-of-packet (one whose reply is due) and the
// bus-activity indication (line not idle).
// Assumes: inputs are already synchronous to clk.
module tat_line_qual (
    input  logic eop_strobe,
    input  logic resp_expected,
    input  logic line_idle,
    output logic eop_qual,
    output logic activity
);

    // Combine strobe and flag; invert idle into activity.
    always_comb begin
        eop_qual = eop_strobe & resp_expected;
        activity = ~line_idle;
    end

endmodule

// File: rtl/tat_arm_ctrl.sv
// Arm/disarm control of the turnaround timer.
// Priority per cycle: qualifying EOP (re-arm) > bus activity (cancel) >
// tick at the limit (expire) > plain tick (count).
// Assumes: at_limit comes from the counter and means count == LIMIT.
module tat_arm_ctrl
    import tat_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic eop_qual,
    input  logic activity,
    input  logic bit_tick,
    input  logic at_limit,
    output logic armed,
    output logic cnt_clr,
    output logic cnt_inc,
    output logic expire
);

    tat_state_e state_q;
    tat_state_e state_d;

    // Next-state and counter command decode.
    always_comb begin
        state_d = state_q;
        cnt_clr = 1'b0;
        cnt_inc = 1'b0;
        expire  = 1'b0;
        if (eop_qual) begin
            state_d = TAT_ARMED;
            cnt_clr = 1'b1;
        end else if (state_q == TAT_ARMED) begin
            if (activity) begin
                state_d = TAT_IDLE;
                cnt_clr = 1'b1;
            end else if (bit_tick && at_limit) begin
                state_d = TAT_IDLE;
                cnt_clr = 1'b1;
                expire  = 1'b1;
            end else if (bit_tick) begin
                cnt_inc = 1'b1;
            end
        end
    end

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TAT_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Expose the arm state.
    always_comb begin
        armed = (state_q == TAT_ARMED);
    end

endmodule

// File: rtl/tat_tick_counter.sv
// Bit-time counter of the turnaround timer.
// Clears on command, increments on command, flags when it holds LIMIT.
// Assumes: the controller never increments past LIMIT.
module tat_tick_counter #(
    parameter int unsigned LIMIT = 16,
    parameter int unsigned CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] count,
    output logic             at_limit
);

    localparam logic [CNT_W-1:0] LIM_V = CNT_W'(LIMIT);

    logic [CNT_W-1:0] cnt_q;

    // Count register: clear has priority over increment.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (inc) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Limit compare and output.
    always_comb begin
        count    = cnt_q;
        at_limit = (cnt_q == LIM_V);
    end

endmodule

// File: rtl/usb_turnaround_timer.sv
// USB bus turnaround timeout timer (top).
// Arms on an end-of-packet whose reply is due, counts full-speed bit ticks
// while the line stays idle, and emits a registered one-cycle pulse when more
// than LIMIT ticks elapse. Leaving idle first cancels silently.
// Assumes: bit_tick, eop_strobe, line_idle and resp_expected are synchronous
// one-clock-domain signals; bit_tick is at most one cycle wide per bit time.
module usb_turnaround_timer #(
    parameter int unsigned LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_tick,
    input  logic eop_strobe,
    input  logic line_idle,
    input  logic resp_expected,
    output logic timeout_pulse
);

    localparam int unsigned CNT_W = tat_pkg::cnt_width(LIMIT);

    logic             eop_qual;
    logic             activity;
    logic             armed;
    logic             cnt_clr;
    logic             cnt_inc;
    logic             expire;
    logic             at_limit;
    logic [CNT_W-1:0] count_q;
    logic             pulse_q;

    tat_line_qual u_qual (
        .eop_strobe    (eop_strobe),
        .resp_expected (resp_expected),
        .line_idle     (line_idle),
        .eop_qual      (eop_qual),
        .activity      (activity)
    );

    tat_arm_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .eop_qual (eop_qual),
        .activity (activity),
        .bit_tick (bit_tick),
        .at_limit (at_limit),
        .armed    (armed),
        .cnt_clr  (cnt_clr),
        .cnt_inc  (cnt_inc),
        .expire   (expire)
    );

    tat_tick_counter #(
        .LIMIT (LIMIT),
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (cnt_clr),
        .inc      (cnt_inc),
        .count    (count_q),
        .at_limit (at_limit)
    );

    // Register the expiry into the one-cycle timeout pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= expire;
        end
    end

    assign timeout_pulse = pulse_q;

endmodule

// File: rtl/tat_checker.sv
// Property checker for the turnaround timer, bound into the top module.
// Assumes: armed and count are the timer's arm state and bit-time count.
module tat_checker #(
    parameter int unsigned LIMIT = 16,
    parameter int unsigned CNT_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bit_tick,
    input logic             eop_strobe,
    input logic             line_idle,
    input logic             resp_expected,
    input logic             timeout_pulse,
    input logic             armed,
    input logic [CNT_W-1:0] count
);

    localparam logic [CNT_W-1:0] LIM_V = CNT_W'(LIMIT);

    logic qual;
    assign qual = eop_strobe & resp_expected;

    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (!armed && count == '0 && !timeout_pulse));

    a_r2_arm_on_eop: assert property (@(posedge clk) disable iff (!rst_n)
        qual |=> (armed && count == '0));

    a_r3_unqualified_eop: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed && !qual) |=> !armed);

    a_r4_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !bit_tick && line_idle && !qual) |=> $stable(count));

    a_r5_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        count <= LIM_V);

    a_r5_pulse_cause: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_pulse |-> $past(armed && bit_tick && line_idle && !qual && count == LIM_V));

    a_r6_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_pulse |=> !timeout_pulse);

    a_r6_disarmed_after: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_pulse |-> !armed);

    a_r7_cancel: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !line_idle && !qual) |=> (!armed && !timeout_pulse));

    a_r9_busy_tick_no_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && bit_tick && !line_idle && !qual) |=> !timeout_pulse);

endmodule

bind usb_turnaround_timer tat_checker #(
    .LIMIT (LIMIT),
    .CNT_W (CNT_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .bit_tick      (bit_tick),
    .eop_strobe    (eop_strobe),
    .line_idle     (line_idle),
    .resp_expected (resp_expected),
    .timeout_pulse (timeout_pulse),
    .armed         (armed),
    .count         (count_q)
);

// File: tb/sim_usb_turnaround_timer.sv
`timescale 1ns/1ps
module sim_usb_turnaround_timer;

    localparam int LIMIT = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_tick = 1'b0;
    logic eop_strobe = 1'b0;
    logic line_idle = 1'b1;
    logic resp_expected = 1'b0;
    logic timeout_pulse;

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    logic last_pulse = 1'b0;

    always #2.5 clk = ~clk;

    usb_turnaround_timer #(.LIMIT(LIMIT)) u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .bit_tick      (bit_tick),
        .eop_strobe    (eop_strobe),
        .line_idle     (line_idle),
        .resp_expected (resp_expected),
        .timeout_pulse (timeout_pulse)
    );

    // Vector: resp flag, tick count, empty cycles before each tick,
    // tick index preceded by a busy cycle (0 = none), expected pulse count,
    // expected tick index of the pulse (0 = none).
    typedef struct packed {
        logic       resp;
        logic [7:0] nticks;
        logic [3:0] gap;
        logic [7:0] cancel_at;
        logic [3:0] exp_n;
        logic [7:0] exp_at;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{1'b1, 8'd17, 4'd0, 8'd0,  4'd1, 8'd17},  // R5 exact limit
        '{1'b1, 8'd16, 4'd0, 8'd0,  4'd0, 8'd0},   // R5 one short
        '{1'b1, 8'd24, 4'd2, 8'd0,  4'd1, 8'd17},  // R4 spaced ticks
        '{1'b0, 8'd24, 4'd0, 8'd0,  4'd0, 8'd0},   // R3 no reply due
        '{1'b1, 8'd24, 4'd0, 8'd5,  4'd0, 8'd0},   // R7 early cancel
        '{1'b1, 8'd24, 4'd1, 8'd17, 4'd0, 8'd0},   // R7 cancel before last tick
        '{1'b1, 8'd30, 4'd0, 8'd0,  4'd1, 8'd17},  // R6 later ticks silent
        '{1'b1, 8'd20, 4'd3, 8'd1,  4'd0, 8'd0}    // R7 cancel at first tick
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One clock cycle with the given inputs; samples the pulse afterwards.
    task automatic step(input logic tk, input logic eop, input logic rsp, input logic idl);
        bit_tick = tk;
        eop_strobe = eop;
        resp_expected = rsp;
        line_idle = idl;
        @(posedge clk);
        @(negedge clk);
        last_pulse = timeout_pulse;
        bit_tick = 1'b0;
        eop_strobe = 1'b0;
        resp_expected = 1'b0;
        line_idle = 1'b1;
    endtask

    // n ticks on an idle line; returns the number of pulse cycles seen.
    task automatic ticks(input int n, output int seen);
        seen = 0;
        for (int k = 0; k < n; k++) begin
            step(1'b1, 1'b0, 1'b0, 1'b1);
            if (last_pulse) seen++;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected below 100000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int n_p;
        int at;
        int seen;

        @(negedge clk);
        step(1'b0, 1'b0, 1'b0, 1'b1);
        step(1'b0, 1'b0, 1'b0, 1'b1);
        chk("R1 reset pulse low", int'(timeout_pulse), 0);
        rst_n = 1'b1;
        ticks(20, seen);
        chk("R1 ticks after reset without EOP", seen, 0);

        // Table walk.
        for (int v = 0; v < 8; v++) begin
            n_p = 0;
            at = 0;
            step(1'b0, 1'b1, VECS[v].resp, 1'b1);
            if (last_pulse) n_p++;
            for (int k = 1; k <= int'(VECS[v].nticks); k++) begin
                for (int g = 0; g < int'(VECS[v].gap); g++) begin
                    step(1'b0, 1'b0, 1'b0, 1'b1);
                    if (last_pulse) n_p++;
                end
                if (k == int'(VECS[v].cancel_at)) begin
                    step(1'b0, 1'b0, 1'b0, 1'b0);
                    if (last_pulse) n_p++;
                end
                step(1'b1, 1'b0, 1'b0, 1'b1);
                if (last_pulse) begin
                    n_p++;
                    at = k;
                end
            end
            chk($sformatf("R5/R6 vector %0d pulse count", v), n_p, int'(VECS[v].exp_n));
            chk($sformatf("R5 vector %0d pulse tick", v), at, int'(VECS[v].exp_at));
            step(1'b0, 1'b0, 1'b0, 1'b0);  // leave disarmed
        end

        // R2: arming starts from zero, pulse width R6.
        step(1'b0, 1'b1, 1'b1, 1'b1);
        ticks(16, seen);
        chk("R2 no pulse after 16 ticks", seen, 0);
        step(1'b1, 1'b0, 1'b0, 1'b1);
        chk("R5 pulse after 17th tick", int'(last_pulse), 1);
        step(1'b0, 1'b0, 1'b0, 1'b1);
        chk("R6 pulse one cycle wide", int'(last_pulse), 0);

        // R8: restart midway.
        step(1'b0, 1'b1, 1'b1, 1'b1);
        ticks(10, seen);
        step(1'b0, 1'b1, 1'b1, 1'b1);
        ticks(16, seen);
        chk("R8 restart: no pulse at 16 after restart", seen, 0);
        ticks(1, seen);
        chk("R8 restart: pulse at 17 after restart", seen, 1);

        // R8: EOP wins over busy line and tick in the same cycle, at the limit.
        step(1'b0, 1'b1, 1'b1, 1'b1);
        ticks(16, seen);
        step(1'b1, 1'b1, 1'b1, 1'b0);
        chk("R8 EOP beats tick at limit", int'(last_pulse), 0);
        ticks(16, seen);
        chk("R8 re-armed count from zero", seen, 0);
        ticks(1, seen);
        chk("R8 re-armed expiry", seen, 1);

        // R9: tick with busy line at the limit cancels.
        step(1'b0, 1'b1, 1'b1, 1'b1);
        ticks(16, seen);
        step(1'b1, 1'b0, 1'b0, 1'b0);
        chk("R9 busy tick at limit", int'(last_pulse), 0);
        ticks(5, seen);
        chk("R9 disarmed after busy tick", seen, 0);

        // R1: reset partway through a count.
        step(1'b0, 1'b1, 1'b1, 1'b1);
        ticks(10, seen);
        rst_n = 1'b0;
        step(1'b0, 1'b0, 1'b0, 1'b1);
        rst_n = 1'b1;
        ticks(20, seen);
        chk("R1 reset disarms mid-count", seen, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule